// File: doc/BRIEF.md
# Delayed-Branch Next-PC Unit

This block holds the architectural program counter as a pair of registers: the address of the instruction retiring now (`pc_o`) and the address that will retire after it (`npc_o`). Every retiring instruction moves `npc_o` into `pc_o`. A taken branch or jump does not change `pc_o` directly. It rewrites `npc_o` instead, so the instruction that sits right behind the branch always executes. That instruction is the single delay slot.

The decoder supplies the opcode, the sub-code field, the destination field, the function code, the 16-bit offset and the 26-bit jump index of the retiring instruction. It also supplies the two register operands. The unit decides whether control transfers and computes the new target. For the linking forms it drives a register-file write request carrying the return address `pc_o + 8`. A separate load port sets the pair to any address, and it takes precedence over retirement. The unit handles only one outstanding redirect, so placing a control transfer in a delay slot is not supported.

Top module: `dslot_pc_unit`

## Requirements
- R1: While reset is asserted, and after it is released, `pc_o` is 0 and `npc_o` is 4 until the first load or retire.
- R2: A cycle with `load_i` high sets `pc_o` to `load_pc_i` and `npc_o` to `load_pc_i + 4`. This takes priority over `retire_i`, and in such a cycle `redirect_o` and `link_we_o` are 0.
- R3: A retire that is not redirected moves `npc_o` into `pc_o` and sets `npc_o` to the old `npc_o + 4`.
- R4: With neither `load_i` nor `retire_i` high, `pc_o` and `npc_o` hold their values.
- R5: Opcode 4 is taken when the two operands are equal, and opcode 5 when they differ. When taken, `npc_o` becomes the old `npc_o` plus the sign-extended offset shifted left by 2, and `pc_o` becomes the old `npc_o`.
- R6: Opcode 6 is taken when the source operand is at most zero, and opcode 7 when it is above zero, both compared as signed values. The target is computed as in R5.
- R7: Opcode 1 tests bit 0 of the sub-code. If the bit is 1 the branch is taken when the source is zero or positive. If it is 0 the branch is taken when the source is negative. The target is computed as in R5.
- R8: Under opcode 1, sub-codes 0x10 and 0x11 request a link write of `pc_o + 8` to register 31, whether or not the branch is taken.
- R9: Opcodes 2 and 3 always jump. The target is the upper 4 bits of `npc_o`, then the 26-bit index, then two zero bits. Opcode 3 also links `pc_o + 8` to register 31.
- R10: Opcode 0 with function 8 jumps to the source operand. Function 9 does the same and also links `pc_o + 8` to the register named by the destination field.
- R11: `link_we_o` and `redirect_o` are high only while `retire_i` is high and `load_i` is low. Any other opcode, or opcode 0 with any other function, asserts neither.
- R12: `redirect_o` is high in exactly the retire cycles whose instruction transfers control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load the PC pair from `load_pc_i` |
| load_pc_i | input | 32 | Address to load |
| retire_i | input | 1 | An instruction retires this cycle |
| opcode_i | input | 6 | Major opcode |
| sub_i | input | 5 | Sub-code field (also the second operand index) |
| rd_i | input | 5 | Destination register field |
| funct_i | input | 6 | Function code for opcode 0 |
| imm_i | input | 16 | Branch offset in words |
| index_i | input | 26 | Absolute jump word index |
| rs_val_i | input | 32 | Source operand value |
| rt_val_i | input | 32 | Second operand value |
| pc_o | output | 32 | Address of the retiring instruction |
| npc_o | output | 32 | Address of the following instruction |
| redirect_o | output | 1 | Control transfer taken this cycle |
| link_we_o | output | 1 | Link write request |
| link_reg_o | output | 5 | Link destination register |
| link_val_o | output | 32 | Link value (`pc_o + 8`) |

## Verification
The link write and the redirect flag are combinational, so they are due in the same cycle as the retiring instruction. The bench drives each instruction on the falling edge and reads these outputs shortly after, before the rising edge. The PC pair changes on the next rising edge, so the bench reads `pc_o` and `npc_o` one time unit after that edge and compares them with a model that advances by one instruction per retire. Idle cycles and load cycles are checked at the same two points, which shows that nothing changes without a retire and that a load overrides a retire.

// File: rtl/dslot_pkg.sv
package dslot_pkg;
  localparam int unsigned OP_W  = 6;
  localparam int unsigned REG_W = 5;
  localparam int unsigned IMM_W = 16;
  localparam int unsigned IDX_W = 26;

  localparam logic [OP_W-1:0] OP_SPECIAL = 6'd0;
  localparam logic [OP_W-1:0] OP_SIGN    = 6'd1;
  localparam logic [OP_W-1:0] OP_JMP     = 6'd2;
  localparam logic [OP_W-1:0] OP_JMPL    = 6'd3;
  localparam logic [OP_W-1:0] OP_EQ      = 6'd4;
  localparam logic [OP_W-1:0] OP_NE      = 6'd5;
  localparam logic [OP_W-1:0] OP_LEZ     = 6'd6;
  localparam logic [OP_W-1:0] OP_GTZ     = 6'd7;

  localparam logic [5:0] FN_JREG  = 6'd8;
  localparam logic [5:0] FN_JREGL = 6'd9;

  localparam logic [REG_W-1:0] SUB_NEG_LINK = 5'h10;
  localparam logic [REG_W-1:0] SUB_POS_LINK = 5'h11;
  localparam logic [REG_W-1:0] RA_REG       = 5'd31;

  typedef enum logic [1:0] {TGT_SEQ, TGT_REL, TGT_ABS, TGT_REG} tgt_kind_e;
endpackage

// File: rtl/dslot_decode.sv
module dslot_decode
  import dslot_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [OP_W-1:0]  opcode_i,
  input  logic [REG_W-1:0] sub_i,
  input  logic [REG_W-1:0] rd_i,
  input  logic [5:0]       funct_i,
  input  logic [XLEN-1:0]  rs_val_i,
  input  logic [XLEN-1:0]  rt_val_i,
  output logic             taken_o,
  output tgt_kind_e        kind_o,
  output logic             link_o,
  output logic [REG_W-1:0] link_reg_o
);
  logic neg, zero;
  assign neg  = rs_val_i[XLEN-1];
  assign zero = (rs_val_i == '0);

  always_comb begin
    taken_o    = 1'b0;
    kind_o     = TGT_SEQ;
    link_o     = 1'b0;
    link_reg_o = RA_REG;
    case (opcode_i)
      OP_EQ:  begin kind_o = TGT_REL; taken_o = (rs_val_i == rt_val_i); end
      OP_NE:  begin kind_o = TGT_REL; taken_o = (rs_val_i != rt_val_i); end
      OP_LEZ: begin kind_o = TGT_REL; taken_o = neg | zero; end
      OP_GTZ: begin kind_o = TGT_REL; taken_o = ~neg & ~zero; end
      OP_SIGN: begin
        kind_o  = TGT_REL;
        taken_o = sub_i[0] ? ~neg : neg;
        // linking forms write the return address regardless of outcome
        link_o  = (sub_i == SUB_NEG_LINK) || (sub_i == SUB_POS_LINK);
      end
      OP_JMP:  begin kind_o = TGT_ABS; taken_o = 1'b1; end
      OP_JMPL: begin kind_o = TGT_ABS; taken_o = 1'b1; link_o = 1'b1; end
      OP_SPECIAL: begin
        if (funct_i == FN_JREG || funct_i == FN_JREGL) begin
          kind_o  = TGT_REG;
          taken_o = 1'b1;
          link_o  = (funct_i == FN_JREGL);
          link_reg_o = rd_i;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dslot_target.sv
module dslot_target
  import dslot_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  tgt_kind_e        kind_i,
  input  logic [XLEN-1:0]  npc_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [IDX_W-1:0] index_i,
  input  logic [XLEN-1:0]  rs_val_i,
  output logic [XLEN-1:0]  target_o
);
  localparam int unsigned SEXT_W = XLEN - IMM_W - 2;
  localparam int unsigned HI_LSB = IDX_W + 2;

  logic [XLEN-1:0] rel_off;
  assign rel_off = {{SEXT_W{imm_i[IMM_W-1]}}, imm_i, 2'b00};

  always_comb begin
    case (kind_i)
      TGT_REL: target_o = npc_i + rel_off;
      TGT_ABS: target_o = {npc_i[XLEN-1:HI_LSB], index_i, 2'b00};
      TGT_REG: target_o = rs_val_i;
      default: target_o = npc_i + XLEN'(4);
    endcase
  end
endmodule

// File: rtl/dslot_pc_unit.sv
module dslot_pc_unit
  import dslot_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [XLEN-1:0]  load_pc_i,
  input  logic             retire_i,
  input  logic [OP_W-1:0]  opcode_i,
  input  logic [REG_W-1:0] sub_i,
  input  logic [REG_W-1:0] rd_i,
  input  logic [5:0]       funct_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [IDX_W-1:0] index_i,
  input  logic [XLEN-1:0]  rs_val_i,
  input  logic [XLEN-1:0]  rt_val_i,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  npc_o,
  output logic             redirect_o,
  output logic             link_we_o,
  output logic [REG_W-1:0] link_reg_o,
  output logic [XLEN-1:0]  link_val_o
);
  localparam logic [XLEN-1:0] STEP  = XLEN'(4);
  localparam logic [XLEN-1:0] RST_A = XLEN'(RESET_PC);

  logic            taken, link, advance;
  tgt_kind_e       kind;
  logic [XLEN-1:0] target, pc_q, npc_q;

  dslot_decode #(.XLEN(XLEN)) dec_i (
    .opcode_i  (opcode_i),
    .sub_i     (sub_i),
    .rd_i      (rd_i),
    .funct_i   (funct_i),
    .rs_val_i  (rs_val_i),
    .rt_val_i  (rt_val_i),
    .taken_o   (taken),
    .kind_o    (kind),
    .link_o    (link),
    .link_reg_o(link_reg_o)
  );

  dslot_target #(.XLEN(XLEN)) tgt_i (
    .kind_i  (kind),
    .npc_i   (npc_q),
    .imm_i   (imm_i),
    .index_i (index_i),
    .rs_val_i(rs_val_i),
    .target_o(target)
  );

  assign advance = retire_i & ~load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= RST_A;
      npc_q <= RST_A + STEP;
    end else if (load_i) begin
      pc_q  <= load_pc_i;
      npc_q <= load_pc_i + STEP;
    end else if (retire_i) begin
      pc_q  <= npc_q;  // delay slot always runs
      npc_q <= taken ? target : npc_q + STEP;
    end
  end

  assign pc_o       = pc_q;
  assign npc_o      = npc_q;
  assign redirect_o = advance & taken;
  assign link_we_o  = advance & link;
  assign link_val_o = pc_q + (STEP << 1);
endmodule

// File: rtl/dslot_pc_unit_chk.sv
module dslot_pc_unit_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            load_i,
  input logic [XLEN-1:0] load_pc_i,
  input logic            retire_i,
  input logic [XLEN-1:0] pc_o,
  input logic [XLEN-1:0] npc_o,
  input logic            redirect_o,
  input logic            link_we_o,
  input logic [XLEN-1:0] link_val_o
);
  assert_load_pair_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (pc_o == $past(load_pc_i)) && (npc_o == $past(load_pc_i) + XLEN'(4)));

  assert_pc_follows_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && !load_i) |=> pc_o == $past(npc_o));

  assert_fallthrough_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && !load_i && !redirect_o) |=> npc_o == $past(npc_o) + XLEN'(4));

  assert_idle_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!retire_i && !load_i) |=> $stable(pc_o) && $stable(npc_o));

  assert_link_value_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> link_val_o == pc_o + XLEN'(8));

  assert_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!retire_i || load_i) |-> (!link_we_o && !redirect_o));
endmodule

bind dslot_pc_unit dslot_pc_unit_chk #(.XLEN(XLEN)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_i    (load_i),
  .load_pc_i (load_pc_i),
  .retire_i  (retire_i),
  .pc_o      (pc_o),
  .npc_o     (npc_o),
  .redirect_o(redirect_o),
  .link_we_o (link_we_o),
  .link_val_o(link_val_o)
);

// File: tb/dslot_pc_unit_tb_top.sv
module dslot_pc_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0;
  logic [31:0] load_pc_i = '0;
  logic        retire_i = 1'b0;
  logic [5:0]  opcode_i = '0;
  logic [4:0]  sub_i = '0;
  logic [4:0]  rd_i = '0;
  logic [5:0]  funct_i = '0;
  logic [15:0] imm_i = '0;
  logic [25:0] index_i = '0;
  logic [31:0] rs_val_i = '0;
  logic [31:0] rt_val_i = '0;
  logic [31:0] pc_o, npc_o, link_val_o;
  logic        redirect_o, link_we_o;
  logic [4:0]  link_reg_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_pc = 32'h0;
  logic [31:0] exp_npc = 32'h4;
  logic [31:0] vals [8] = '{32'h0, 32'h1, 32'h2, 32'hFFFF_FFFF, 32'hFFFF_FFFE,
                            32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_1234};

  always #(CLK_PERIOD/2) clk = ~clk;

  dslot_pc_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load_i), .load_pc_i(load_pc_i),
    .retire_i(retire_i), .opcode_i(opcode_i), .sub_i(sub_i), .rd_i(rd_i),
    .funct_i(funct_i), .imm_i(imm_i), .index_i(index_i), .rs_val_i(rs_val_i),
    .rt_val_i(rt_val_i), .pc_o(pc_o), .npc_o(npc_o), .redirect_o(redirect_o),
    .link_we_o(link_we_o), .link_reg_o(link_reg_o), .link_val_o(link_val_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_pair(input string req);
    chk(pc_o == exp_pc, {req, " pc"}, pc_o, exp_pc);
    chk(npc_o == exp_npc, {req, " npc"}, npc_o, exp_npc);
  endtask

  // one retiring instruction; expectations derived from the requirements
  task automatic run(input logic [5:0] op, input logic [4:0] sub, input logic [4:0] rd,
                     input logic [5:0] fn, input logic [15:0] imm, input logic [25:0] idx,
                     input logic [31:0] rsv, input logic [31:0] rtv, input string req);
    bit tk, lnk;
    logic [4:0]  lreg;
    logic [31:0] tgt, rel;
    rel  = exp_npc + ({{16{imm[15]}}, imm} << 2);
    tk = 0; lnk = 0; lreg = 5'd31; tgt = 32'h0;
    case (op)
      6'd4: begin tk = (rsv == rtv); tgt = rel; end
      6'd5: begin tk = (rsv != rtv); tgt = rel; end
      6'd6: begin tk = ($signed(rsv) <= 0); tgt = rel; end
      6'd7: begin tk = ($signed(rsv) > 0); tgt = rel; end
      6'd1: begin
        tk  = sub[0] ? ($signed(rsv) >= 0) : ($signed(rsv) < 0);
        tgt = rel;
        lnk = (sub == 5'h10) || (sub == 5'h11);
      end
      6'd2: begin tk = 1; tgt = {exp_npc[31:28], idx, 2'b00}; end
      6'd3: begin tk = 1; lnk = 1; tgt = {exp_npc[31:28], idx, 2'b00}; end
      6'd0: if (fn == 6'd8 || fn == 6'd9) begin
        tk = 1; tgt = rsv; lnk = (fn == 6'd9); lreg = rd;
      end
      default: ;
    endcase
    @(negedge clk);
    opcode_i = op; sub_i = sub; rd_i = rd; funct_i = fn; imm_i = imm;
    index_i = idx; rs_val_i = rsv; rt_val_i = rtv; retire_i = 1'b1;
    #1;
    chk(redirect_o == tk, {req, " R12 redirect"}, 32'(redirect_o), 32'(tk));
    chk(link_we_o == lnk, {req, " link_we"}, 32'(link_we_o), 32'(lnk));
    if (lnk) begin
      chk(link_reg_o == lreg, {req, " link_reg"}, 32'(link_reg_o), 32'(lreg));
      chk(link_val_o == exp_pc + 8, {req, " link_val"}, link_val_o, exp_pc + 8);
    end
    @(posedge clk); #1;
    exp_pc  = exp_npc;
    exp_npc = tk ? tgt : exp_npc + 4;
    check_pair(req);
    retire_i = 1'b0;
  endtask

  task automatic do_load(input logic [31:0] v, input bit also_retire);
    @(negedge clk);
    load_i = 1'b1; load_pc_i = v; retire_i = also_retire;
    opcode_i = 6'd3; index_i = 26'h155_5555;
    #1;
    chk(!redirect_o && !link_we_o, "R2 load masks retire", {30'b0, redirect_o, link_we_o}, 32'h0);
    @(posedge clk); #1;
    load_i = 1'b0; retire_i = 1'b0;
    exp_pc = v; exp_npc = v + 4;
    check_pair("R2 load");
  endtask

  task automatic idle(input logic [5:0] op);
    @(negedge clk);
    retire_i = 1'b0; opcode_i = op; funct_i = 6'd9;
    #1;
    chk(!redirect_o && !link_we_o, "R11 idle quiet", {30'b0, redirect_o, link_we_o}, 32'h0);
    @(posedge clk); #1;
    check_pair("R4 idle hold");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog act=%h exp=%h", n_chk, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    check_pair("R1 in reset");
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;
    check_pair("R1 after reset");
    idle(6'd3);

    // R5 R6: compare branches over operand pairs and offsets
    for (int op = 4; op <= 7; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run(6'(op), 5'd0, 5'd0, 6'd0, 16'(i * 37 - j * 91), 26'd0, vals[i], vals[j],
              (op < 6) ? "R5 eq/ne" : "R6 lez/gtz");

    // R7 R8: sign-test branches, with and without linking
    for (int s = 0; s < 6; s++)
      for (int i = 0; i < 8; i++) begin
        logic [4:0] sc;
        sc = (s < 2) ? 5'(s) : (s < 4) ? 5'(16 + s - 2) : 5'(s);
        run(6'd1, sc, 5'd0, 6'd0, 16'(i * 300 - 1000), 26'd0, vals[i], 32'h0,
            (sc[4]) ? "R8 sign link" : "R7 sign test");
      end

    do_load(32'hA000_0100, 1'b0);
    // R9: absolute jumps keep upper nibble of the slot address
    for (int k = 0; k < 16; k++)
      run((k % 2 == 0) ? 6'd2 : 6'd3, 5'd0, 5'd0, 6'd0, 16'd0,
          26'(k * 32'h0012_3457), 32'h0, 32'h0, "R9 jump");

    // R10: register jumps, linking to rd
    for (int k = 0; k < 16; k++)
      run(6'd0, 5'd0, 5'(k * 3), (k % 2 == 0) ? 6'd8 : 6'd9, 16'd0, 26'd0,
          32'h4000_0000 + 32'(k * 32'h10), 32'h0, "R10 reg jump");

    // R11: non-control instructions fall through
    run(6'd0, 5'd0, 5'd4, 6'h20, 16'h8000, 26'h3FF_FFFF, 32'hFFFF_FFF0, 32'h0, "R11 alu op");
    run(6'd8, 5'h11, 5'd4, 6'd9, 16'h7FFF, 26'h3FF_FFFF, 32'h0, 32'h0, "R11 imm op");
    run(6'h20, 5'h10, 5'd4, 6'd8, 16'h0004, 26'h3FF_FFFF, 32'h0, 32'h0, "R11 load op");
    run(6'd0, 5'd0, 5'd4, 6'd10, 16'h0, 26'h0, 32'h1234_0000, 32'h0, "R11 funct 10");

    // R4 + delay slot: taken branch, idle, then slot retires
    run(6'd4, 5'd0, 5'd0, 6'd0, 16'h0010, 26'd0, 32'h5, 32'h5, "R5 taken before idle");
    idle(6'd2);
    idle(6'd0);
    run(6'd0, 5'd0, 5'd0, 6'h20, 16'h0, 26'd0, 32'h0, 32'h0, "R3 slot retires");
    run(6'd0, 5'd0, 5'd0, 6'h20, 16'h0, 26'd0, 32'h0, 32'h0, "R3 at target");

    do_load(32'h0000_0FFC, 1'b1);
    do_load(32'hFFFF_FFF8, 1'b0);
    run(6'd0, 5'd0, 5'd0, 6'h21, 16'h0, 26'd0, 32'h0, 32'h0, "R3 wrap");
    run(6'd5, 5'd0, 5'd0, 6'd0, 16'hFFFF, 26'd0, 32'h1, 32'h2, "R5 negative offset");

    @(negedge clk); rst_ni = 1'b0; #1;
    exp_pc = 32'h0; exp_npc = 32'h4;
    check_pair("R1 async reset");
    rst_ni = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule